// File: doc/BRIEF.md
# DRAM Parallel Test Compressor

This block is the data path between the four data pins of a DRAM and a 32-bit array port. In normal mode it moves one 4-bit word per access. The word is placed by the full 11-bit column address. In test mode, column bits 0, 1 and 10 stop selecting anything. Each pin then covers eight array locations at once. A write copies each pin's level into all eight of its locations in one 32-bit transfer. A read reduces the eight stored bits behind each pin to one equal/not-equal result, so a tester can check the whole array in an eighth of the accesses.

The 32-bit port holds eight 4-bit words. The group index is g = {col[10], col[1], col[0]}. Word g sits at bits 4g+3..4g, and pin p of word g is bit 4g+p. Column bits 9..2 form the port address. The block samples a request on a rising clock edge and drives the array port for the cycle that follows. The array returns read data combinationally in that same cycle. Requests must be at least three cycles apart. Decoding of test-mode entry and exit is outside this block: `testMode` is an input sampled with each request.

Top module: `dram_test_compressor`

## Requirements
- R1: After reset, `dqOe`, `arrWrEn` and `arrRdEn` are low and no request is in flight.
- R2: In the cycle after a normal-mode write request is sampled, the array port carries the following: `arrWrEn` high, `arrAddr` = col[9:2], `arrWrMask` set only at bits 4g+3..4g, and pin p's level at bit 4g+p. Only that nibble of the stored word changes.
- R3: A normal-mode read drives `arrRdData[4g+3:4g]` on `dqOut`, with `dqOe` high. The result appears for one cycle, starting at the second rising edge after the request is sampled.
- R4: A test-mode write drives an all-ones `arrWrMask`, and every one of the eight nibbles of the 32-bit word gets the pin levels.
- R5: On a test-mode read, pin p is driven high when its eight bits (4g+p for g = 0..7) are all 1 or all 0.
- R6: On a test-mode read, pin p is driven low when any of its eight bits differ. Each pin is judged independently of the others.
- R7: A test-mode read result appears one edge later than a normal read: `dqOe` is still low at the second edge after the request and high for one cycle from the third.
- R8: `dqOe` is low outside the single read-valid cycle, including during and after writes in both modes.
- R9: In test mode, column bits 0, 1 and 10 have no effect: accesses differing only in those bits give the same port address, the same mask and the same read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access request, sampled on the rising edge |
| accWrite | input | 1 | 1 = write, 0 = read |
| testMode | input | 1 | Selects compressed test access for this request |
| colAddr | input | 11 | Column address |
| dqIn | input | 4 | Data pin levels for a write |
| dqOut | output | 4 | Read data or per-pin pass/fail |
| dqOe | output | 1 | Data pins driven; high-impedance when low |
| arrAddr | output | 8 | Array port word address (col[9:2]) |
| arrWrEn | output | 1 | Array write strobe |
| arrWrMask | output | 32 | Per-bit write enable to the array |
| arrWrData | output | 32 | Write data to the array |
| arrRdEn | output | 1 | Array read strobe |
| arrRdData | input | 32 | Read data from the array, combinational |

## Verification
The bench builds the block with its default widths: four pins, an 11-bit column and eight groups. These defaults give every group index 0 to 7 through bit 10 together with bits 1..0, so the bench can reach the highest group and the top bit of the column. A 256-word array model sits on the port and preloads patterns. These include all-zero and all-one words, a single flipped bit in the last group, and mixed pins. They exercise the equal and not-equal results per pin at both extremes. The bench sweeps the three ignored column bits against a fixed word address, and it measures the extra edge of test-read latency cycle by cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef struct packed {
    logic load;     // capture write data with the request
    logic portWr;   // array write cycle
    logic portRd;   // array read cycle
    logic testQ;    // request in flight is a test-mode access
    logic capNorm;  // latch normal read nibble onto the pins
    logic capTest;  // latch compressed result into the hold stage
    logic outTest;  // drive held compressed result onto the pins
  } ctrlStrobe_t;
endpackage

// File: rtl/tcmp_ctrl.sv
module tcmp_ctrl
  import tcmp_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             testMode,
  input  logic [COL_W-1:0] colAddr,
  output ctrlStrobe_t      st,
  output logic [COL_W-1:0] colQ
);
  logic s1Valid, s1Write, s1Test, s2TestRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Write  <= 1'b0;
      s1Test   <= 1'b0;
      s2TestRd <= 1'b0;
      colQ     <= '0;
    end else begin
      s1Valid  <= accValid;
      s2TestRd <= s1Valid & ~s1Write & s1Test;
      if (accValid) begin
        s1Write <= accWrite;
        s1Test  <= testMode;
        colQ    <= colAddr;
      end
    end
  end

  always_comb begin
    st.load    = accValid;
    st.portWr  = s1Valid & s1Write;
    st.portRd  = s1Valid & ~s1Write;
    st.testQ   = s1Test;
    st.capNorm = s1Valid & ~s1Write & ~s1Test;
    st.capTest = s1Valid & ~s1Write & s1Test;
    st.outTest = s2TestRd;
  end

  // R2
  wr_from_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.portWr |-> $past(accValid && accWrite));
endmodule

// File: rtl/tcmp_datapath.sv
module tcmp_datapath
  import tcmp_pkg::*;
#(
  parameter int DQ_W  = 4,
  parameter int COL_W = 11,
  parameter int SEL_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   st,
  input  logic [COL_W-1:0]              colQ,
  input  logic [DQ_W-1:0]               dqIn,
  input  logic [DQ_W*(1<<SEL_W)-1:0]    arrRdData,
  output logic [COL_W-4:0]              arrAddr,
  output logic                          arrWrEn,
  output logic [DQ_W*(1<<SEL_W)-1:0]    arrWrMask,
  output logic [DQ_W*(1<<SEL_W)-1:0]    arrWrData,
  output logic                          arrRdEn,
  output logic [DQ_W-1:0]               dqOut,
  output logic                          dqOe
);
  localparam int GRP_N = 1 << SEL_W;
  localparam int ARR_W = DQ_W * GRP_N;

  logic [SEL_W-1:0] grpSel;
  logic [DQ_W-1:0]  wrDataQ, nibble, pinEq, cmpQ;
  logic [ARR_W-1:0] normMask;

  assign grpSel    = {colQ[COL_W-1], colQ[1:0]};
  assign arrAddr   = colQ[COL_W-2:2];
  assign arrWrEn   = st.portWr;
  assign arrRdEn   = st.portRd;
  assign arrWrData = {GRP_N{wrDataQ}};
  assign arrWrMask = !st.portWr ? '0 : (st.testQ ? '1 : normMask);
  assign nibble    = arrRdData[grpSel*DQ_W +: DQ_W];

  for (genvar g = 0; g < GRP_N; g++) begin : g_mask
    assign normMask[g*DQ_W +: DQ_W] = (grpSel == g) ? '1 : '0;
  end

  for (genvar p = 0; p < DQ_W; p++) begin : g_pin
    logic [GRP_N-1:0] pinBits;
    for (genvar g = 0; g < GRP_N; g++) begin : g_bit
      assign pinBits[g] = arrRdData[g*DQ_W + p];
    end
    assign pinEq[p] = (&pinBits) | ~(|pinBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrDataQ <= '0;
      cmpQ    <= '0;
      dqOut   <= '0;
      dqOe    <= 1'b0;
    end else begin
      if (st.load)    wrDataQ <= dqIn;
      if (st.capTest) cmpQ    <= pinEq;
      if (st.capNorm)      dqOut <= nibble;
      else if (st.outTest) dqOut <= cmpQ;
      dqOe <= st.capNorm | st.outTest;
    end
  end

  // R6
  fail_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capTest && !(&arrRdData[DQ_W-1:0] == 1'b0 && 1'b0) && (pinEq[0] == 1'b0) |=> !cmpQ[0]);
endmodule

// File: rtl/dram_test_compressor.sv
module dram_test_compressor
  import tcmp_pkg::*;
#(
  parameter int DQ_W  = 4,
  parameter int COL_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              testMode,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [COL_W-4:0]  arrAddr,
  output logic              arrWrEn,
  output logic [DQ_W*8-1:0] arrWrMask,
  output logic [DQ_W*8-1:0] arrWrData,
  output logic              arrRdEn,
  input  logic [DQ_W*8-1:0] arrRdData
);
  localparam int SEL_W = 3;

  ctrlStrobe_t      st;
  logic [COL_W-1:0] colQ;

  tcmp_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .testMode(testMode), .colAddr(colAddr), .st(st), .colQ(colQ)
  );

  tcmp_datapath #(.DQ_W(DQ_W), .COL_W(COL_W), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .colQ(colQ), .dqIn(dqIn),
    .arrRdData(arrRdData), .arrAddr(arrAddr), .arrWrEn(arrWrEn),
    .arrWrMask(arrWrMask), .arrWrData(arrWrData), .arrRdEn(arrRdEn),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  // R4
  test_mask_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn && $past(testMode) |-> &arrWrMask);

  // R2
  norm_mask_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn && !$past(testMode) |-> $countones(arrWrMask) == DQ_W);

  // R8
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> ($past(arrRdEn) || $past(arrRdEn, 2)));

  // R1
  port_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(arrWrEn && arrRdEn));
endmodule

// File: tb/test_dram_test_compressor.sv
module test_dram_test_compressor;
  localparam int DQ_W = 4, COL_W = 11, ARR_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, testMode = 1'b0;
  logic [COL_W-1:0] colAddr = '0;
  logic [DQ_W-1:0]  dqIn = '0, dqOut;
  logic dqOe, arrWrEn, arrRdEn;
  logic [COL_W-4:0] arrAddr;
  logic [ARR_W-1:0] arrWrMask, arrWrData, arrRdData;
  logic [ARR_W-1:0] mem [256];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dram_test_compressor i_dram_test_compressor (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .testMode(testMode), .colAddr(colAddr), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .arrAddr(arrAddr), .arrWrEn(arrWrEn), .arrWrMask(arrWrMask),
    .arrWrData(arrWrData), .arrRdEn(arrRdEn), .arrRdData(arrRdData)
  );

  assign arrRdData = mem[arrAddr];
  always @(posedge clk)
    if (arrWrEn) mem[arrAddr] <= (mem[arrAddr] & ~arrWrMask) | (arrWrData & arrWrMask);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int grpOf(logic [COL_W-1:0] c);
    return {c[10], c[1], c[0]};
  endfunction

  function automatic logic [3:0] cmpRef(logic [ARR_W-1:0] w);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) begin
      int ones = 0;
      for (int g = 0; g < 8; g++) ones += w[4*g+p];
      r[p] = (ones == 0 || ones == 8);
    end
    return r;
  endfunction

  // request sampled on the edge between the two negedges; returns after that edge
  task automatic issue(logic wr, logic tm, logic [COL_W-1:0] c, logic [3:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; testMode = tm; colAddr = c; dqIn = d;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; testMode = 1'b0; dqIn = '0;
  endtask

  task automatic normWrite(logic [COL_W-1:0] c, logic [3:0] d, logic [ARR_W-1:0] pre);
    logic [ARR_W-1:0] expM, expW;
    int g = grpOf(c);
    mem[c[9:2]] = pre;
    expM = 32'hF << (4*g);
    expW = (pre & ~expM) | ({8{d}} & expM);
    issue(1'b1, 1'b0, c, d);
    chk("R2 wr strobe", arrWrEn, 1'b1);
    chk("R2 wr mask", arrWrMask, expM);
    chk("R2 wr addr", arrAddr, c[9:2]);
    chk("R8 oe during write", dqOe, 1'b0);
    @(negedge clk);
    chk("R2 stored word", mem[c[9:2]], expW);
    chk("R8 oe after write", dqOe, 1'b0);
    @(negedge clk);
    chk("R8 oe late after write", dqOe, 1'b0);
  endtask

  task automatic normRead(logic [COL_W-1:0] c, logic [ARR_W-1:0] w);
    int g = grpOf(c);
    mem[c[9:2]] = w;
    issue(1'b0, 1'b0, c, 4'h0);
    chk("R3 rd strobe", arrRdEn, 1'b1);
    chk("R3 oe not yet", dqOe, 1'b0);
    @(negedge clk);
    chk("R3 oe window", dqOe, 1'b1);
    chk("R3 nibble", dqOut, w[4*g +: 4]);
    @(negedge clk);
    chk("R8 oe closes", dqOe, 1'b0);
  endtask

  task automatic testWrite(logic [COL_W-1:0] c, logic [3:0] d);
    mem[c[9:2]] = 32'h5A3C_96E1;
    issue(1'b1, 1'b1, c, d);
    chk("R4 mask all ones", arrWrMask, 32'hFFFF_FFFF);
    chk("R9 test addr", arrAddr, c[9:2]);
    @(negedge clk);
    chk("R4 replicated word", mem[c[9:2]], {8{d}});
    chk("R8 oe after test write", dqOe, 1'b0);
  endtask

  task automatic testRead(string req, logic [COL_W-1:0] c, logic [ARR_W-1:0] w);
    mem[c[9:2]] = w;
    issue(1'b0, 1'b1, c, 4'h0);
    chk("R9 test rd addr", arrAddr, c[9:2]);
    @(negedge clk);
    chk("R7 oe held back", dqOe, 1'b0);
    @(negedge clk);
    chk("R7 oe window", dqOe, 1'b1);
    chk(req, dqOut, cmpRef(w));
    @(negedge clk);
    chk("R8 oe closes", dqOe, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe reset", dqOe, 1'b0);
    chk("R1 wr reset", arrWrEn, 1'b0);
    chk("R1 rd reset", arrRdEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {dqOe, arrWrEn, arrRdEn}, 3'b000);

    normWrite(11'h000, 4'hA, 32'h0000_0000);
    normWrite(11'h407, 4'h5, 32'hFFFF_FFFF);
    normWrite(11'h2A5, 4'hC, 32'h1234_5678);
    normRead(11'h000, 32'h8765_4321);
    normRead(11'h403, 32'hC0DE_F00D);
    normRead(11'h7FF, 32'hABCD_EF01);

    testWrite(11'h0F4, 4'h9);
    testWrite(11'h4F7, 4'h6);
    testRead("R5 all ones pass", 11'h010, 32'hFFFF_FFFF);
    testRead("R5 all zeros pass", 11'h011, 32'h0000_0000);
    testRead("R5 mixed pins equal", 11'h020, 32'h5555_5555);
    testRead("R6 flip pin2 group7", 11'h030, 32'hBFFF_FFFF);
    testRead("R6 flip pin0 group0", 11'h040, 32'h0000_0001);
    testRead("R6 several pins differ", 11'h050, 32'h0F0F_FA3C);
    for (int k = 0; k < 8; k++) begin
      logic [COL_W-1:0] c = {k[2], 8'h66, k[1:0]};
      testRead("R9 ignored bits same result", c, 32'hF7FF_FFEF);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule